// File: doc/BRIEF.md
# Serial BCH(63,56) Codeblock Error Decoder

This block takes one 64-bit codeblock, delivered one bit at a time with the most significant bit first, and decides what to do with it. The first 56 bits carry information. The next 7 bits are parity bits, which the sender complements. The last bit is a filler bit. While the bits arrive, the decoder inverts the parity bits back, divides the 63 code bits by the generator x^7 + x^6 + x^2 + 1 to form a 7-bit syndrome, and keeps the overall parity of the 63 bits. Because the generator contains the factor (x+1), every valid codeword has even weight. Odd overall parity therefore means that an odd number of bits were corrupted.

After the 64th valid bit the decoder gives one of three verdicts: accept, accept after a single-bit correction, or reject. A correction is allowed only when the filler bit is 0. To find the bad bit, the decoder compares the syndrome against x^e mod g(x), one exponent per clock. If the matching exponent belongs to an information bit, that bit is inverted on the output. A `blk_start` strobe abandons whatever block is in progress and readies the decoder for the next one.

Top module: `bch_codeblock_dec`

## Requirements
- R1: After `rst`, and in the cycle after any `blk_start`, the outputs `done`, `accept`, `corrected` and `reject` are 0 and `info_out` is all zeros.
- R2: A codeblock formed as 56 information bits, then the complement of the 7-bit remainder of info·x^7 mod (x^7+x^6+x^2+1), then a filler bit of either value, is accepted. In that case `corrected` is 0 and `info_out` equals the 56 information bits, with the first received bit at `info_out[55]`.
- R3: If exactly one of the first 56 received bits is flipped and the filler bit is 0, the block is accepted with `corrected`=1, and `info_out` holds the original information bits.
- R4: If exactly one of the 7 parity bits (received positions 56 to 62) is flipped and the filler bit is 0, the block is accepted with `corrected`=1 and `info_out` unchanged.
- R5: If exactly one code bit is flipped and the filler bit is 1, the block is rejected. `accept` and `corrected` are 0, and `info_out` shows the received information bits without correction.
- R6: If exactly two code bits are flipped, the block is rejected whatever the filler bit is.
- R7: Cycles with `bit_vld`=0 are ignored whatever the value of `bit_in`. `done` is a one-cycle pulse, asserted exactly once per block, after the 64th valid bit. The verdict flags hold their values until the next `blk_start`.
- R8: A `blk_start` in the middle of a block discards the bits received so far. The next 64 valid bits are decoded as a fresh block.
- R9: Valid bits that arrive after the 64th valid bit and before the next `blk_start` are ignored. They produce no further `done` pulse and leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Start of a new codeblock; clears all state |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial codeblock bit, most significant first |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| accept | output | 1 | Block accepted (possibly corrected) |
| corrected | output | 1 | Block accepted after single-error correction |
| reject | output | 1 | Block rejected |
| info_out | output | 56 | Information bits, first received at bit 55 |

## Verification
The hardest case to reach from the ports is a correction whose error lies at the far end of the locator's search. An error in the first received bit only matches on the 63rd search cycle, and its correction lands on the top output bit. The bench reaches this case by sweeping a single flipped bit across all 63 code positions with filler 0, using encoded blocks it computes itself by polynomial long division. Between bits it inserts idle cycles that carry junk data, and it also sends trailing extra bits and aborted partial blocks. These exercise the bit counter's edges.

// File: rtl/bch_dec_pkg.sv
package bch_dec_pkg;

  typedef enum logic [1:0] {
    VERD_ACCEPT = 2'd0,
    VERD_FIX    = 2'd1,
    VERD_REJECT = 2'd2
  } verdict_t;

  // Decision from syndrome state, overall code parity and filler bit.
  function automatic verdict_t classify(input logic syn_zero,
                                        input logic par_odd,
                                        input logic filler);
    verdict_t v;
    if (!par_odd)     v = syn_zero ? VERD_ACCEPT : VERD_REJECT;
    else if (syn_zero) v = VERD_REJECT;
    else if (filler)   v = VERD_REJECT;
    else               v = VERD_FIX;
    return v;
  endfunction

endpackage

// File: rtl/bch_syn_accum.sv
module bch_syn_accum #(
  parameter int INFO_W = 56,
  parameter int PAR_W  = 7,
  parameter logic [PAR_W-1:0] GEN_LOW = 7'h45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic [PAR_W-1:0]  syn,
  output logic              par_odd,
  output logic              filler,
  output logic [INFO_W-1:0] info,
  output logic              blk_end
);
  localparam int CODE_W = INFO_W + PAR_W;
  localparam int BLK_W  = CODE_W + 1;
  localparam int CNT_W  = $clog2(BLK_W + 1);
  localparam logic [CNT_W-1:0] C_INFO = CNT_W'(INFO_W);
  localparam logic [CNT_W-1:0] C_CODE = CNT_W'(CODE_W);
  localparam logic [CNT_W-1:0] C_BLK  = CNT_W'(BLK_W);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(BLK_W - 1);

  logic [CNT_W-1:0] cnt;
  logic             cbit;
  logic [PAR_W-1:0] syn_next;

  // Parity bits arrive complemented; restore them before division.
  always_comb begin
    cbit     = (cnt >= C_INFO) ? ~bit_in : bit_in;
    syn_next = {syn[PAR_W-2:0], cbit} ^ (syn[PAR_W-1] ? GEN_LOW : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      syn     <= '0;
      par_odd <= 1'b0;
      filler  <= 1'b0;
      info    <= '0;
      blk_end <= 1'b0;
    end else begin
      blk_end <= 1'b0;
      if (bit_vld && (cnt < C_BLK)) begin
        cnt <= cnt + 1'b1;
        if (cnt < C_CODE) begin
          syn     <= syn_next;
          par_odd <= par_odd ^ cbit;
          if (cnt < C_INFO) info <= {info[INFO_W-2:0], bit_in};
        end else begin
          filler <= bit_in;
        end
        if (cnt == C_LAST) blk_end <= 1'b1;
      end
    end
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= C_BLK);

  assert_end_once_R7: assert property (@(posedge clk) disable iff (rst || clr)
    blk_end |=> !blk_end);

endmodule

// File: rtl/bch_err_locate.sv
module bch_err_locate #(
  parameter int PAR_W  = 7,
  parameter int CODE_W = 63,
  parameter logic [PAR_W-1:0] GEN_LOW = 7'h45,
  localparam int POS_W = $clog2(CODE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PAR_W-1:0] syn,
  output logic             fin,
  output logic             found,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] E_LAST = POS_W'(CODE_W - 1);

  logic             busy;
  logic [PAR_W-1:0] pw;      // x^e mod g(x)
  logic [POS_W-1:0] e;
  logic [PAR_W-1:0] pw_next;

  always_comb pw_next = {pw[PAR_W-2:0], 1'b0} ^ (pw[PAR_W-1] ? GEN_LOW : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      found <= 1'b0;
      pos   <= '0;
      pw    <= '0;
      e     <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        found <= 1'b0;
        pw    <= PAR_W'(1);
        e     <= '0;
      end else if (busy) begin
        if (pw == syn) begin
          busy  <= 1'b0;
          fin   <= 1'b1;
          found <= 1'b1;
          pos   <= e;
        end else if (e == E_LAST) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          pw <= pw_next;
          e  <= e + 1'b1;
        end
      end
    end
  end

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  assert_fin_idle_R3: assert property (@(posedge clk) disable iff (rst)
    fin |-> !busy);

  assert_pos_range_R4: assert property (@(posedge clk) disable iff (rst)
    found |-> (pos <= E_LAST));

endmodule

// File: rtl/bch_codeblock_dec.sv
module bch_codeblock_dec #(
  parameter int INFO_W = 56,
  parameter int PAR_W  = 7,
  parameter logic [PAR_W-1:0] GEN_LOW = 7'h45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_start,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              done,
  output logic              accept,
  output logic              corrected,
  output logic              reject,
  output logic [INFO_W-1:0] info_out
);
  import bch_dec_pkg::*;

  localparam int CODE_W = INFO_W + PAR_W;
  localparam int POS_W  = $clog2(CODE_W);

  typedef enum logic [1:0] {ST_RUN, ST_SEEK, ST_HOLD} st_t;

  st_t              st;
  logic [PAR_W-1:0] syn;
  logic             par_odd, filler, blk_end;
  logic [INFO_W-1:0] info;
  logic             loc_start, loc_fin, loc_found;
  logic [POS_W-1:0] loc_pos;
  logic [INFO_W-1:0] flip;
  verdict_t         verd;
  logic             clr_all;

  assign clr_all = rst || blk_start;

  bch_syn_accum #(.INFO_W(INFO_W), .PAR_W(PAR_W), .GEN_LOW(GEN_LOW)) u_syn (
    .clk(clk), .rst(rst), .clr(blk_start), .bit_vld(bit_vld), .bit_in(bit_in),
    .syn(syn), .par_odd(par_odd), .filler(filler), .info(info), .blk_end(blk_end)
  );

  bch_err_locate #(.PAR_W(PAR_W), .CODE_W(CODE_W), .GEN_LOW(GEN_LOW)) u_loc (
    .clk(clk), .rst(clr_all), .start(loc_start), .syn(syn),
    .fin(loc_fin), .found(loc_found), .pos(loc_pos)
  );

  always_comb verd = classify(syn == '0, par_odd, filler);

  // Exponents at or above PAR_W fall in the information field.
  always_comb begin
    for (int i = 0; i < INFO_W; i++)
      flip[i] = loc_found && (loc_pos == POS_W'(i + PAR_W));
  end

  always_ff @(posedge clk) begin
    if (clr_all) begin
      st        <= ST_RUN;
      done      <= 1'b0;
      accept    <= 1'b0;
      corrected <= 1'b0;
      reject    <= 1'b0;
      info_out  <= '0;
      loc_start <= 1'b0;
    end else begin
      done      <= 1'b0;
      loc_start <= 1'b0;
      case (st)
        ST_RUN: if (blk_end) begin
          case (verd)
            VERD_ACCEPT: begin
              done <= 1'b1; accept <= 1'b1; info_out <= info; st <= ST_HOLD;
            end
            VERD_FIX: begin
              loc_start <= 1'b1; st <= ST_SEEK;
            end
            default: begin
              done <= 1'b1; reject <= 1'b1; info_out <= info; st <= ST_HOLD;
            end
          endcase
        end
        ST_SEEK: if (loc_fin) begin
          done      <= 1'b1;
          accept    <= 1'b1;
          corrected <= 1'b1;
          info_out  <= info ^ flip;
          st        <= ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_one_verdict_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (accept != reject));

  assert_fix_accepts_R3: assert property (@(posedge clk) disable iff (rst)
    corrected |-> (accept && !reject));

  assert_hold_flags_R7: assert property (@(posedge clk) disable iff (rst || blk_start)
    (!done && $past(!blk_start) && $past(!rst)) |-> ($stable(accept) && $stable(reject)));

endmodule

// File: tb/tb_bch_codeblock_dec.sv
module tb_bch_codeblock_dec;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, blk_start = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic done, accept, corrected, reject;
  logic [55:0] info_out;

  int checks = 0, fails = 0;
  int n_done;
  logic c_acc, c_cor, c_rej;
  logic [55:0] c_info;

  always #(CLK_PERIOD/2) clk = ~clk;

  bch_codeblock_dec dut (
    .clk(clk), .rst(rst), .blk_start(blk_start), .bit_vld(bit_vld), .bit_in(bit_in),
    .done(done), .accept(accept), .corrected(corrected), .reject(reject),
    .info_out(info_out)
  );

  function automatic logic [6:0] enc_par(input logic [55:0] m);
    logic [62:0] v;
    v = {m, 7'b0};
    for (int i = 62; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'hC5;
    return v[6:0];
  endfunction

  function automatic logic [63:0] mk(input logic [55:0] m, input logic f);
    return {m, ~enc_par(m), f};
  endfunction

  // Code position k (0 = first received) lives at block bit 63-k.
  function automatic logic [63:0] hit(input int k);
    return 64'd1 << (63 - k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    blk_start = 1'b1; @(negedge clk); blk_start = 1'b0;
  endtask

  task automatic send_bits(input logic [63:0] blk, input int nbits, input int gap);
    for (int i = 63; i > 63 - nbits; i--) begin
      bit_vld = 1'b1; bit_in = blk[i];
      @(negedge clk);
      if (done) begin n_done++; c_acc = accept; c_cor = corrected; c_rej = reject; c_info = info_out; end
      if (gap != 0 && (i % gap) == 0) begin
        bit_vld = 1'b0; bit_in = ~bit_in;
        @(negedge clk);
        if (done) begin n_done++; c_acc = accept; c_cor = corrected; c_rej = reject; c_info = info_out; end
      end
    end
    bit_vld = 1'b0;
  endtask

  task automatic wait_done(input int cyc);
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (done) begin n_done++; c_acc = accept; c_cor = corrected; c_rej = reject; c_info = info_out; end
    end
  endtask

  task automatic run(input logic [63:0] blk, input int gap, input string req,
                     input logic ea, input logic ec, input logic er, input logic [55:0] ei);
    n_done = 0;
    pulse_start();
    send_bits(blk, 64, gap);
    wait_done(75);
    chk(n_done == 1, req, "done count", 64'(n_done), 64'd1);
    chk({c_acc, c_cor, c_rej} == {ea, ec, er}, req, "acc/cor/rej",
        {61'd0, c_acc, c_cor, c_rej}, {61'd0, ea, ec, er});
    chk(c_info == ei, req, "info", {8'd0, c_info}, {8'd0, ei});
  endtask

  logic [55:0] pats [6];

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pats[0] = 56'h0;
    pats[1] = 56'hFF_FFFF_FFFF_FFFF;
    pats[2] = 56'hA5_5A3C_C3F0_0F96;
    pats[3] = 56'h80_0000_0000_0001;
    pats[4] = 56'h12_3456_789A_BCDE;
    pats[5] = 56'h00_0001_0000_0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({done, accept, corrected, reject} == 4'b0 && info_out == '0, "R1", "after reset",
        {4'd0, done, accept, corrected, reject, info_out}, 64'd0);

    // R2 clean blocks, both filler values, with and without gaps
    for (int p = 0; p < 6; p++)
      for (int f = 0; f < 2; f++)
        run(mk(pats[p], f[0]), (p % 2) ? 3 : 0, "R2", 1'b1, 1'b0, 1'b0, pats[p]);

    // R1 blk_start clears held verdict
    pulse_start();
    chk({done, accept, corrected, reject} == 4'b0 && info_out == '0, "R1", "after blk_start",
        {4'd0, done, accept, corrected, reject, info_out}, 64'd0);

    // R3 single info-bit error sweep, filler 0
    for (int k = 0; k < 56; k++)
      run(mk(pats[k % 6], 1'b0) ^ hit(k), (k % 4 == 1) ? 7 : 0, "R3",
          1'b1, 1'b1, 1'b0, pats[k % 6]);

    // R4 single parity-bit error sweep, filler 0
    for (int k = 56; k < 63; k++)
      run(mk(pats[k % 6], 1'b0) ^ hit(k), 0, "R4", 1'b1, 1'b1, 1'b0, pats[k % 6]);

    // R5 single error with filler 1: rejected, info as received
    for (int k = 0; k < 63; k += 9) begin
      logic [63:0] b;
      b = mk(pats[2], 1'b1) ^ hit(k);
      run(b, 0, "R5", 1'b0, 1'b0, 1'b1, b[63:8]);
    end
    begin
      logic [63:0] b;
      b = mk(pats[4], 1'b1) ^ hit(62);
      run(b, 0, "R5", 1'b0, 1'b0, 1'b1, b[63:8]);
    end

    // R6 double errors, both fillers
    for (int k = 0; k < 63; k += 2) begin
      int j;
      logic [63:0] b;
      j = (k * 7 + 5) % 63;
      if (j == k) j = (k + 1) % 63;
      b = mk(pats[k % 6], k[1]) ^ hit(k) ^ hit(j);
      run(b, 0, "R6", 1'b0, 1'b0, 1'b1, b[63:8]);
    end

    // R9 trailing bits after the 64th are ignored
    begin
      logic [63:0] b;
      b = mk(pats[4], 1'b0) ^ hit(10);
      run(b, 0, "R9", 1'b1, 1'b1, 1'b0, pats[4]);
      n_done = 0;
      send_bits(~b, 20, 0);
      wait_done(70);
      chk(n_done == 0, "R9", "extra done", 64'(n_done), 64'd0);
      chk(accept && corrected && !reject && info_out == pats[4], "R9", "outputs held",
          {5'd0, accept, corrected, reject, info_out}, {5'd0, 3'b110, pats[4]});
    end

    // R8 abort partial block then decode a fresh one
    begin
      n_done = 0;
      pulse_start();
      send_bits(mk(pats[1], 1'b0) ^ hit(3) ^ hit(40), 37, 0);
      chk(n_done == 0, "R8", "no done on partial", 64'(n_done), 64'd0);
      run(mk(pats[2], 1'b0) ^ hit(0), 5, "R8", 1'b1, 1'b1, 1'b0, pats[2]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule